// File: doc/BRIEF.md
# Hough vote accumulator with threshold scan

This block holds the parameter space of a line-finding Hough transform as a grid of small saturating counters. Rows stand for quantised signed distance from the image centre (rho) and columns for quantised angle (theta). Upstream logic computes one rho per angle step for every edge pixel and presents each (rho, theta) pair as a vote on a valid/ready input. Each accepted vote adds one to the bin it addresses. Because the origin sits at the image centre and theta covers only half a turn, rho is signed. It is moved onto a row index by adding half the row count.

Once a frame has been voted in, a scan request walks every bin in row-major order. The walk compares each count against a constant threshold and streams the passing bins out on a valid/ready output as (rho, theta, count). A single-cycle done pulse closes the walk. A clear request zeroes the whole grid one bin per cycle before the next frame, and a clear also runs by itself after reset. Votes that fall outside the grid are dropped and raise a sticky flag, which the next clear resets.

The vote path is a two-stage read-modify-write pipeline. It forwards the freshly incremented count when consecutive votes hit the same bin, so no increment is lost.

Top module: `hough_acc`

## Requirements
- R1: After reset the block clears every bin, one per cycle, with vote_ready low. It reaches the accumulate state, with vote_ready high, N_ROWS*N_THETA cycles after reset is released. During and right after reset, pk_valid, scan_done and overflow are low.
- R2: An accepted vote with signed rho r and theta t, where 0 <= r + N_ROWS/2 < N_ROWS and t < N_THETA, adds exactly one to the bin at row r + N_ROWS/2, column t. By default rho -8..7 maps to rows 0..15 and theta 0..11 maps to columns 0..11.
- R3: A vote whose row falls outside 0..N_ROWS-1 or whose theta is N_THETA or above changes no bin. It sets overflow, which stays high through accumulating and scanning until the next clear.
- R4: A bin count saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R5: Votes accepted on consecutive cycles to the same bin are each counted, including when they alternate between two bins.
- R6: vote_ready is high only in the accumulate state. clear_req and scan_req act only in that state and are ignored elsewhere. If both are high in the same cycle, the clear wins.
- R7: A scan emits every bin whose count is at least thresh, and only those. Bins come in row-major order: rho ascending in the outer loop, theta ascending in the inner loop. pk_rho = row - N_ROWS/2 and pk_count is the bin's count.
- R8: While pk_valid is high and pk_ready is low, pk_valid, pk_rho, pk_theta and pk_count hold steady. No peak is lost or repeated under back-pressure.
- R9: scan_done is a one-cycle pulse in the cycle after the last bin is examined, and vote_ready is high in that same cycle. When the last bin passes and the output is free, its peak is on the output in the done cycle.
- R10: A clear zeroes every bin and drops overflow on the cycle it starts. A later scan with thresh 1 emits nothing, and one with thresh 0 emits every bin with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_req | input | 1 | Start a clear of the grid (acted on in accumulate state) |
| scan_req | input | 1 | Start a threshold scan (acted on in accumulate state) |
| thresh | input | CNT_W | Minimum count for a bin to be emitted |
| vote_valid | input | 1 | Vote present |
| vote_ready | output | 1 | Vote accepted this cycle when valid |
| vote_rho | input | RHO_W | Signed rho of the vote |
| vote_theta | input | TH_W | Theta column of the vote |
| pk_valid | output | 1 | Peak present |
| pk_ready | input | 1 | Consumer takes the peak |
| pk_rho | output | RHO_W | Signed rho of the peak bin |
| pk_theta | output | TH_W | Theta column of the peak bin |
| pk_count | output | CNT_W | Vote count of the peak bin |
| scan_done | output | 1 | One-cycle pulse closing a scan |
| overflow | output | 1 | Sticky flag: a vote fell outside the grid |

## Verification
The two functions that share a cycle are the write-back of one vote and the read of the next vote aimed at the same bin. They are provoked by streams of same-bin votes on consecutive cycles, and by votes that alternate between two bins. The bench keeps its own count per bin and judges the result by the counts a later scan reports. A second overlap is a mode request arriving together with in-flight votes, or together with another request. It is judged by the vote_ready and overflow levels in the following cycle, and by the output of a follow-up scan.

// File: rtl/hough_acc_pkg.sv
package hough_acc_pkg;

    // Operating state of the accumulator; reset value is the clearing state.
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_ACCUM = 2'd1,
        MODE_SCAN  = 2'd2
    } mode_e;

endpackage

// File: rtl/hough_vote_map.sv
// Maps a signed rho and a theta column onto a linear bin index (row-major).
module hough_vote_map #(
    parameter int RHO_W   = 6,
    parameter int TH_W    = 4,
    parameter int N_ROWS  = 16,
    parameter int N_THETA = 12,
    parameter int IDX_W   = 8
) (
    input  logic signed [RHO_W-1:0] rho,
    input  logic        [TH_W-1:0]  theta,
    output logic        [IDX_W-1:0] idx,
    output logic                    in_range
);
    localparam int HALF = N_ROWS / 2;

    int row_i;
    int col_i;

    always_comb begin
        row_i    = int'(rho) + HALF;
        col_i    = int'(theta);
        in_range = (row_i >= 0) && (row_i < N_ROWS) && (col_i < N_THETA);
        idx      = in_range ? IDX_W'(row_i * N_THETA + col_i) : '0;
    end

endmodule

// File: rtl/hough_bin_array.sv
// Register grid of bin counters: one write port, one combinational read port.
module hough_bin_array #(
    parameter int N_BINS = 192,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    logic [CNT_W-1:0] cells [N_BINS];

    for (genvar g = 0; g < N_BINS; g++) begin : g_cell
        logic [CNT_W-1:0] c_q;
        // No reset: contents are defined by the clear walk.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                c_q <= wr_cnt;
            end
        end
        assign cells[g] = c_q;
    end

    assign rd_cnt = cells[rd_idx];

endmodule

// File: rtl/hough_acc.sv
module hough_acc
    import hough_acc_pkg::*;
#(
    parameter int RHO_W   = 6,
    parameter int N_ROWS  = 16,
    parameter int N_THETA = 12,
    parameter int TH_W    = 4,
    parameter int CNT_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_req,
    input  logic                    scan_req,
    input  logic        [CNT_W-1:0] thresh,
    input  logic                    vote_valid,
    output logic                    vote_ready,
    input  logic signed [RHO_W-1:0] vote_rho,
    input  logic        [TH_W-1:0]  vote_theta,
    output logic                    pk_valid,
    input  logic                    pk_ready,
    output logic signed [RHO_W-1:0] pk_rho,
    output logic        [TH_W-1:0]  pk_theta,
    output logic        [CNT_W-1:0] pk_count,
    output logic                    scan_done,
    output logic                    overflow
);
    localparam int N_BINS = N_ROWS * N_THETA;
    localparam int IDX_W  = $clog2(N_BINS);
    localparam int ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
    localparam int HALF   = N_ROWS / 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BINS - 1);
    localparam logic [TH_W-1:0]  LAST_COL = TH_W'(N_THETA - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        mode_e            mode;
        logic [IDX_W-1:0] walk;    // linear bin pointer for clear and scan
        logic [ROW_W-1:0] row;     // scan row, follows walk
        logic [TH_W-1:0]  col;     // scan column, follows walk
        logic             a_vld;   // stage A: index captured, read issued
        logic [IDX_W-1:0] a_idx;
        logic             b_vld;   // stage B: old count held, write-back
        logic [IDX_W-1:0] b_idx;
        logic [CNT_W-1:0] b_cnt;
        logic             ovf;
        logic             pk_vld;
        logic [ROW_W-1:0] pk_row;
        logic [TH_W-1:0]  pk_col;
        logic [CNT_W-1:0] pk_cnt;
        logic             done;
    } st_t;

    localparam st_t ST_RST = '{mode: MODE_CLEAR, default: '0};

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + CNT_W'(1);
    endfunction

    st_t s_q, s_d;

    logic [IDX_W-1:0] map_idx;
    logic             map_ok;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] rd_cnt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] wr_cnt;
    logic             drained;
    logic             accept;
    logic             slot_free;

    hough_vote_map #(
        .RHO_W(RHO_W), .TH_W(TH_W), .N_ROWS(N_ROWS), .N_THETA(N_THETA), .IDX_W(IDX_W)
    ) u_map (
        .rho(vote_rho), .theta(vote_theta), .idx(map_idx), .in_range(map_ok)
    );

    hough_bin_array #(
        .N_BINS(N_BINS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_bins (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cnt(wr_cnt),
        .rd_idx(rd_idx), .rd_cnt(rd_cnt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        drained   = !s_q.a_vld && !s_q.b_vld;
        accept    = vote_valid && (s_q.mode == MODE_ACCUM);
        slot_free = !s_q.pk_vld || pk_ready;

        // vote pipeline: capture, read with forwarding, write back
        s_d.a_vld = accept && map_ok;
        s_d.a_idx = map_idx;
        if (accept && !map_ok) begin
            s_d.ovf = 1'b1;
        end
        s_d.b_vld = s_q.a_vld;
        s_d.b_idx = s_q.a_idx;
        s_d.b_cnt = (s_q.b_vld && (s_q.b_idx == s_q.a_idx)) ? sat_inc(s_q.b_cnt) : rd_cnt;

        rd_idx = s_q.a_vld ? s_q.a_idx : s_q.walk;
        wr_en  = s_q.b_vld;
        wr_idx = s_q.b_idx;
        wr_cnt = sat_inc(s_q.b_cnt);

        if (s_q.pk_vld && pk_ready) begin
            s_d.pk_vld = 1'b0;
        end

        case (s_q.mode)
            MODE_CLEAR: begin
                s_d.ovf = 1'b0;
                if (drained) begin
                    wr_en  = 1'b1;
                    wr_idx = s_q.walk;
                    wr_cnt = '0;
                    if (s_q.walk == LAST_IDX) begin
                        s_d.mode = MODE_ACCUM;
                        s_d.walk = '0;
                    end else begin
                        s_d.walk = s_q.walk + IDX_W'(1);
                    end
                end
            end
            MODE_ACCUM: begin
                if (clear_req) begin
                    s_d.mode = MODE_CLEAR;
                    s_d.walk = '0;
                    s_d.ovf  = 1'b0;
                end else if (scan_req) begin
                    s_d.mode = MODE_SCAN;
                    s_d.walk = '0;
                    s_d.row  = '0;
                    s_d.col  = '0;
                end
            end
            MODE_SCAN: begin
                if (drained && slot_free) begin
                    if (rd_cnt >= thresh) begin
                        s_d.pk_vld = 1'b1;
                        s_d.pk_row = s_q.row;
                        s_d.pk_col = s_q.col;
                        s_d.pk_cnt = rd_cnt;
                    end
                    if (s_q.col == LAST_COL) begin
                        s_d.col = '0;
                        s_d.row = s_q.row + ROW_W'(1);
                    end else begin
                        s_d.col = s_q.col + TH_W'(1);
                    end
                    if (s_q.walk == LAST_IDX) begin
                        s_d.mode = MODE_ACCUM;
                        s_d.walk = '0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.walk = s_q.walk + IDX_W'(1);
                    end
                end
            end
            default: s_d.mode = MODE_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign vote_ready = (s_q.mode == MODE_ACCUM);
    assign pk_valid   = s_q.pk_vld;
    assign pk_rho     = RHO_W'(int'(s_q.pk_row) - HALF);
    assign pk_theta   = s_q.pk_col;
    assign pk_count   = s_q.pk_cnt;
    assign scan_done  = s_q.done;
    assign overflow   = s_q.ovf;

endmodule

// File: rtl/hough_acc_chk.sv
module hough_acc_chk #(
    parameter int RHO_W = 6,
    parameter int TH_W  = 4,
    parameter int CNT_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear_req,
    input logic                    scan_req,
    input logic        [CNT_W-1:0] thresh,
    input logic                    vote_ready,
    input logic                    pk_valid,
    input logic                    pk_ready,
    input logic signed [RHO_W-1:0] pk_rho,
    input logic        [TH_W-1:0]  pk_theta,
    input logic        [CNT_W-1:0] pk_count,
    input logic                    scan_done,
    input logic                    overflow
);
    a_r6_scan_blocks_votes: assert property (@(posedge clk) disable iff (!rst_n)
        vote_ready && scan_req && !clear_req |=> !vote_ready);

    a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        vote_ready && clear_req |=> !overflow && !vote_ready);

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(vote_ready && clear_req) |=> overflow);

    a_r8_peak_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid && !pk_ready |=> pk_valid && $stable(pk_rho) && $stable(pk_theta) && $stable(pk_count));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    a_r9_done_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> vote_ready);

    a_r7_peak_passes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pk_valid) && $stable(thresh) |-> pk_count >= thresh);

endmodule

bind hough_acc hough_acc_chk #(.RHO_W(RHO_W), .TH_W(TH_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .scan_req(scan_req),
    .thresh(thresh), .vote_ready(vote_ready), .pk_valid(pk_valid), .pk_ready(pk_ready),
    .pk_rho(pk_rho), .pk_theta(pk_theta), .pk_count(pk_count),
    .scan_done(scan_done), .overflow(overflow)
);

// File: tb/tb_hough_acc.sv
module tb_hough_acc;
    localparam int RHO_W   = 6;
    localparam int N_ROWS  = 16;
    localparam int N_THETA = 12;
    localparam int TH_W    = 4;
    localparam int CNT_W   = 4;
    localparam int N_BINS  = N_ROWS * N_THETA;
    localparam int HALF    = N_ROWS / 2;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    clear_req = 1'b0;
    logic                    scan_req = 1'b0;
    logic        [CNT_W-1:0] thresh = '0;
    logic                    vote_valid = 1'b0;
    logic                    vote_ready;
    logic signed [RHO_W-1:0] vote_rho = '0;
    logic        [TH_W-1:0]  vote_theta = '0;
    logic                    pk_valid;
    logic                    pk_ready = 1'b1;
    logic signed [RHO_W-1:0] pk_rho;
    logic        [TH_W-1:0]  pk_theta;
    logic        [CNT_W-1:0] pk_count;
    logic                    scan_done;
    logic                    overflow;

    hough_acc #(
        .RHO_W(RHO_W), .N_ROWS(N_ROWS), .N_THETA(N_THETA), .TH_W(TH_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .scan_req(scan_req),
        .thresh(thresh), .vote_valid(vote_valid), .vote_ready(vote_ready),
        .vote_rho(vote_rho), .vote_theta(vote_theta), .pk_valid(pk_valid),
        .pk_ready(pk_ready), .pk_rho(pk_rho), .pk_theta(pk_theta), .pk_count(pk_count),
        .scan_done(scan_done), .overflow(overflow)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    int model [N_ROWS][N_THETA];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic zero_model();
        for (int r = 0; r < N_ROWS; r++)
            for (int t = 0; t < N_THETA; t++)
                model[r][t] = 0;
    endtask

    // Drive one vote, wait for acceptance, update the reference counts (R2, R3, R4).
    task automatic send_vote(input int rho, input int th);
        int row;
        @(negedge clk);
        vote_valid = 1'b1;
        vote_rho   = RHO_W'(rho);
        vote_theta = TH_W'(th);
        #1;
        while (!vote_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        row = rho + HALF;
        if (row >= 0 && row < N_ROWS && th < N_THETA && model[row][th] < CMAX)
            model[row][th]++;
    endtask

    task automatic end_votes();
        @(negedge clk);
        vote_valid = 1'b0;
    endtask

    // Scan with threshold thr; bp applies back-pressure on the peak output.
    // Compares the emitted stream with the row-major list from the model (R7).
    task automatic run_scan(input int thr, input bit bp, input string req);
        int er[$], et[$], ec[$];
        int gr[$], gt[$], gc[$];
        bit done_seen = 0;
        bit hold = 0;
        int h_rho = 0, h_th = 0, h_cnt = 0;
        int cyc = 0;
        bit last_pass;
        for (int r = 0; r < N_ROWS; r++)
            for (int t = 0; t < N_THETA; t++)
                if (model[r][t] >= thr) begin
                    er.push_back(r - HALF); et.push_back(t); ec.push_back(model[r][t]);
                end
        last_pass = (model[N_ROWS-1][N_THETA-1] >= thr) && !bp;
        @(negedge clk);
        thresh   = CNT_W'(thr);
        scan_req = 1'b1;
        pk_ready = 1'b1;
        @(negedge clk);
        scan_req = 1'b0;
        #1;
        chk(!vote_ready, "R6", "vote_ready while scanning", int'(vote_ready), 0);
        forever begin
            if (hold) begin
                chk(pk_valid && int'(pk_rho) == h_rho && int'(pk_theta) == h_th && int'(pk_count) == h_cnt,
                    "R8", "peak held under back-pressure",
                    int'(pk_rho) * 100 + int'(pk_theta), h_rho * 100 + h_th);
            end
            if (scan_done) begin
                done_seen = 1;
                chk(vote_ready, "R9", "vote_ready in done cycle", int'(vote_ready), 1);
                if (last_pass)
                    chk(pk_valid && int'(pk_rho) == N_ROWS - 1 - HALF && int'(pk_theta) == N_THETA - 1,
                        "R9", "last bin peak in done cycle",
                        int'(pk_valid) * 10000 + int'(pk_rho) * 100 + int'(pk_theta),
                        10000 + (N_ROWS - 1 - HALF) * 100 + N_THETA - 1);
            end
            if (pk_valid && pk_ready) begin
                gr.push_back(int'(pk_rho)); gt.push_back(int'(pk_theta)); gc.push_back(int'(pk_count));
            end
            hold  = pk_valid && !pk_ready;
            h_rho = int'(pk_rho); h_th = int'(pk_theta); h_cnt = int'(pk_count);
            if (done_seen && !pk_valid) break;
            if (done_seen && pk_valid && pk_ready && !hold) begin
                @(negedge clk); #1;
                if (!pk_valid) break;
            end else begin
                @(negedge clk);
                cyc++;
                pk_ready = done_seen ? 1'b1 : (bp ? (cyc % 3 != 0) : 1'b1);
                #1;
            end
        end
        @(negedge clk); #1;
        chk(!scan_done, "R9", "done lasts one cycle", int'(scan_done), 0);
        chk(gr.size() == er.size(), req, "number of peaks", gr.size(), er.size());
        for (int i = 0; i < er.size() && i < gr.size(); i++)
            chk(gr[i] == er[i] && gt[i] == et[i] && gc[i] == ec[i], req, "peak (row,theta,count)",
                (gr[i] + HALF) * 10000 + gt[i] * 100 + gc[i],
                (er[i] + HALF) * 10000 + et[i] * 100 + ec[i]);
    endtask

    task automatic t_reset();
        int n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!vote_ready, "R1", "vote_ready after reset", int'(vote_ready), 0);
        chk(!pk_valid && !scan_done, "R1", "outputs idle after reset", int'(pk_valid) + int'(scan_done), 0);
        chk(!overflow, "R1", "overflow after reset", int'(overflow), 0);
        while (!vote_ready) begin
            @(negedge clk); #1;
            n++;
        end
        chk(n >= N_BINS && n <= N_BINS + 2, "R1", "cycles of clear after reset", n, N_BINS);
        zero_model();
    endtask

    task automatic t_basic();
        send_vote(0, 0); send_vote(0, 0); send_vote(-8, 3); send_vote(5, 7);
        send_vote(-1, 11); send_vote(3, 2); send_vote(3, 2); send_vote(3, 2);
        end_votes();
        run_scan(1, 0, "R2");
        run_scan(2, 0, "R7");
    endtask

    task automatic t_forward();
        for (int i = 0; i < 6; i++) send_vote(-3, 5);
        for (int i = 0; i < 3; i++) begin send_vote(2, 4); send_vote(2, 5); end
        send_vote(2, 4); send_vote(2, 4);
        end_votes();
        run_scan(3, 1, "R5");   // back-pressure also exercises R8
    endtask

    task automatic t_saturate();
        for (int i = 0; i < CMAX + 5; i++) send_vote(N_ROWS - 1 - HALF, N_THETA - 1);
        end_votes();
        run_scan(CMAX, 0, "R4");
    endtask

    task automatic t_range();
        #1;
        chk(!overflow, "R3", "overflow before stray votes", int'(overflow), 0);
        send_vote(HALF, 0); send_vote(-HALF - 1, 1); send_vote(0, N_THETA); send_vote(-HALF, 0);
        end_votes();
        repeat (3) @(negedge clk);
        #1;
        chk(overflow, "R3", "overflow after stray votes", int'(overflow), 1);
        run_scan(1, 0, "R3");
        #1;
        chk(overflow, "R3", "overflow kept across scan", int'(overflow), 1);
    endtask

    task automatic t_requests();
        int n = 0;
        bit stray = 0;
        @(negedge clk);
        clear_req = 1'b1;
        scan_req  = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        scan_req  = 1'b0;
        #1;
        chk(!vote_ready, "R6", "vote_ready after both requests", int'(vote_ready), 0);
        chk(!overflow, "R10", "overflow dropped by clear", int'(overflow), 0);
        @(negedge clk);
        scan_req = 1'b1;          // must be ignored while clearing
        @(negedge clk);
        scan_req = 1'b0;
        #1;
        while (!vote_ready) begin
            if (pk_valid) stray = 1;
            @(negedge clk); #1;
            n++;
        end
        for (int i = 0; i < 6; i++) begin
            if (pk_valid || !vote_ready) stray = 1;
            @(negedge clk); #1;
        end
        chk(!stray, "R6", "request during clear ignored", int'(stray), 0);
        chk(n < N_BINS + 4, "R10", "clear length", n, N_BINS);
        zero_model();
        run_scan(1, 0, "R10");
        run_scan(0, 1, "R10");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_forward();
        t_saturate();
        t_range();
        t_requests();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule